// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block holds the program counter of a small vertex-shader core and decides on each clock where the next instruction comes from. The decoder gives it the flow-control fields of the instruction at the current fetch address. The block then either moves on to the next word, jumps, or opens a nested region (a subroutine, either arm of a two-way branch, or a counted loop). The arithmetic datapath, operand swizzling and the register files sit outside this block.

All nested constructs share one bounded region stack. Each entry holds an end address, a return address, a loop-start address, a repeat count and a loop-register increment. At the start of every cycle, before anything executes, the current PC is compared with the end address of the top entry. On a match that cycle is spent closing the region and no instruction is consumed. Because the check is repeated on the new PC, several regions that end at the same address unwind on consecutive cycles. The `issue` output tells the decoder whether the word at `fetch_addr` is executed in the current cycle.

Top module: `shader_flow_seq`

## Requirements
- R1: Reset, and a cycle with `start` high, set the PC to `main_offset` (0 for reset), empty the stack, and clear `loop_reg`, `overflow_err` and `high_water`. `issue` is low in a cycle with `start` high.
- R2: An issued instruction with opcode 0 (sequential), or with any code above 8, moves the PC to PC+1, wrapping at the address width.
- R3: The stack holds at most DEPTH entries. A push when it is full leaves the stack unchanged and sets `overflow_err`, and the PC update of that instruction still takes place. `overflow_err` stays set until reset or `start`.
- R4: Opcode 1 (jump on condition) and opcode 2 (jump on the boolean uniform chosen by `bool_sel`) load `dest` into the PC when taken. Otherwise they fall through to PC+1.
- R5: Opcode 3 (call), and opcodes 4 and 5 (call on condition, call on boolean uniform) when their test holds, set the PC to `dest` and push end = dest+count, return = PC+1, start = dest, with a repeat count and increment of 0. A call whose test fails falls through.
- R6: Opcode 6 (branch on condition) and opcode 7 (branch on boolean uniform) always push. If taken, the PC goes to PC+1 with end = dest and return = dest+count. If not taken, the PC goes to dest with end = return = dest+count and start = dest.
- R7: Opcode 8 (loop) loads `loop_reg` with `int_y`, moves the PC to PC+1, and pushes start = PC+1, end = return = dest+1, repeat = `int_x` and increment = `int_z`. The body therefore runs `int_x`+1 times.
- R8: When the stack is non-empty and the PC equals the top entry's end address, `issue` is low and `loop_reg` gains the top increment. If the top repeat count is zero, the PC takes the return address and the entry is popped. Otherwise the count drops by one and the PC takes the start address.
- R9: The condition compares `ref_x` with `flag_x` and `ref_y` with `flag_y`. `cond_mode` selects how the two matches combine: 0 = either, 1 = both, 2 = X only, 3 = Y only.
- R10: `high_water` holds the largest fetched PC+1 over all issued cycles since the last reset or `start`. It never changes in a cycle where nothing is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new program at `main_offset` |
| main_offset | input | ADDR_W | Entry address of the program |
| op | input | 4 | Flow-control opcode of the word at `fetch_addr` |
| dest | input | ADDR_W | Destination offset field |
| count | input | CNT_W | Instruction count field |
| ref_x | input | 1 | Reference bit for flag X |
| ref_y | input | 1 | Reference bit for flag Y |
| cond_mode | input | 2 | Condition combine mode |
| flag_x | input | 1 | Condition flag X |
| flag_y | input | 1 | Condition flag Y |
| bool_uni | input | BOOL_N | Boolean uniforms |
| bool_sel | input | SEL_W | Index of the boolean uniform tested |
| int_x | input | UNI_W | Integer uniform X (loop repeat count) |
| int_y | input | UNI_W | Integer uniform Y (loop register start value) |
| int_z | input | UNI_W | Integer uniform Z (loop register step) |
| fetch_addr | output | ADDR_W | Current PC and fetch address |
| issue | output | 1 | The word at `fetch_addr` executes this cycle |
| loop_reg | output | UNI_W | Loop address register |
| overflow_err | output | 1 | Sticky stack-overflow flag |
| high_water | output | ADDR_W+1 | Highest fetched PC+1 |

## Verification
The bench builds the block with ADDR_W=8, DEPTH=4 and BOOL_N=8. The 256-word program space lets randomly generated programs wrap around and land on every address, and their destinations often fall back into regions that are already open. With a four-deep stack, a short chain of calls reaches overflow, and random nesting regularly fills the stack, so both the full-stack push and the recovery through `start` are exercised. A directed program includes an empty loop nested inside a call that ends at the same address, which forces two region ends in a row.

// File: rtl/shader_flow_pkg.sv
// Shared encodings for the shader flow-control sequencer.
// Assumes the decoder presents opcodes with the values below; any other
// code is treated as a plain sequential instruction.
package shader_flow_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SEQ   = 4'd0,
        OP_JMPC  = 4'd1,
        OP_JMPU  = 4'd2,
        OP_CALL  = 4'd3,
        OP_CALLC = 4'd4,
        OP_CALLU = 4'd5,
        OP_IFC   = 4'd6,
        OP_IFU   = 4'd7,
        OP_LOOP  = 4'd8
    } flow_op_e;

    typedef enum logic [1:0] {
        CM_EITHER = 2'd0,
        CM_BOTH   = 2'd1,
        CM_X_ONLY = 2'd2,
        CM_Y_ONLY = 2'd3
    } cond_mode_e;

endpackage

// File: rtl/flow_cond_eval.sv
// Condition evaluator: matches each reference bit against its flag and
// combines the two matches as the mode field selects.
// Assumes purely combinational use; no state.
module flow_cond_eval
    import shader_flow_pkg::*;
(
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic       flag_x,
    input  logic       flag_y,
    input  logic [1:0] mode,
    output logic       pass
);

    logic hit_x;
    logic hit_y;

    // Compare each reference with its flag and combine per mode.
    always_comb begin
        hit_x = (ref_x == flag_x);
        hit_y = (ref_y == flag_y);
        case (mode)
            CM_EITHER: pass = hit_x | hit_y;
            CM_BOTH:   pass = hit_x & hit_y;
            CM_X_ONLY: pass = hit_x;
            default:   pass = hit_y;
        endcase
    end

endmodule

// File: rtl/flow_decode.sv
// Flow-control decoder: for an instruction that issues, works out the next
// PC, whether a region is pushed and with which fields, and whether the loop
// register is loaded. Assumes count fits the address space after zero-extension
// or truncation to ADDR_W.
module flow_decode
    import shader_flow_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int UNI_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] dest,
    input  logic [CNT_W-1:0]  count,
    input  logic              cond_ok,
    input  logic              bool_ok,
    input  logic [UNI_W-1:0]  int_x,
    input  logic [UNI_W-1:0]  int_y,
    input  logic [UNI_W-1:0]  int_z,
    output logic [ADDR_W-1:0] next_pc,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_end,
    output logic [ADDR_W-1:0] push_ret,
    output logic [ADDR_W-1:0] push_start,
    output logic [UNI_W-1:0]  push_cnt,
    output logic [UNI_W-1:0]  push_inc,
    output logic              loop_load,
    output logic [UNI_W-1:0]  loop_val
);

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] tail;
    logic [ADDR_W-1:0] dest_inc;
    logic              branch_taken;

    assign pc_inc   = pc + ADDR_W'(1);
    assign tail     = dest + ADDR_W'(count);
    assign dest_inc = dest + ADDR_W'(1);

    // Select next PC and region fields from the opcode.
    always_comb begin
        next_pc      = pc_inc;
        push_req     = 1'b0;
        push_end     = tail;
        push_ret     = pc_inc;
        push_start   = dest;
        push_cnt     = '0;
        push_inc     = '0;
        loop_load    = 1'b0;
        loop_val     = int_y;
        branch_taken = (op == OP_IFC) ? cond_ok : bool_ok;
        case (op)
            OP_JMPC: if (cond_ok) next_pc = dest;
            OP_JMPU: if (bool_ok) next_pc = dest;
            OP_CALL: begin
                next_pc  = dest;
                push_req = 1'b1;
            end
            OP_CALLC: if (cond_ok) begin
                next_pc  = dest;
                push_req = 1'b1;
            end
            OP_CALLU: if (bool_ok) begin
                next_pc  = dest;
                push_req = 1'b1;
            end
            OP_IFC, OP_IFU: begin
                push_req = 1'b1;
                push_ret = tail;
                if (branch_taken) begin
                    next_pc    = pc_inc;
                    push_end   = dest;
                    push_start = pc_inc;
                end else begin
                    next_pc    = dest;
                end
            end
            OP_LOOP: begin
                loop_load  = 1'b1;
                push_req   = 1'b1;
                push_end   = dest_inc;
                push_ret   = dest_inc;
                push_start = pc_inc;
                push_cnt   = int_x;
                push_inc   = int_z;
            end
            default: next_pc = pc_inc;
        endcase
    end

endmodule

// File: rtl/region_stack.sv
// Bounded region stack: one register slot per level, the top entry exposed
// combinationally. Assumes push and pop never occur in the same cycle; a push
// while full is dropped (the caller flags it). DEPTH must be at least 2.
module region_stack #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 12,
    parameter int UNI_W  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic              dec_top,
    input  logic [ADDR_W-1:0] in_end,
    input  logic [ADDR_W-1:0] in_ret,
    input  logic [ADDR_W-1:0] in_start,
    input  logic [UNI_W-1:0]  in_cnt,
    input  logic [UNI_W-1:0]  in_inc,
    output logic              empty,
    output logic              full,
    output logic [LVL_W-1:0]  level,
    output logic [ADDR_W-1:0] top_end,
    output logic [ADDR_W-1:0] top_ret,
    output logic [ADDR_W-1:0] top_start,
    output logic [UNI_W-1:0]  top_cnt,
    output logic [UNI_W-1:0]  top_inc
);

    logic [ADDR_W-1:0] s_end   [DEPTH];
    logic [ADDR_W-1:0] s_ret   [DEPTH];
    logic [ADDR_W-1:0] s_start [DEPTH];
    logic [UNI_W-1:0]  s_cnt   [DEPTH];
    logic [UNI_W-1:0]  s_inc   [DEPTH];
    logic [IDX_W-1:0]  top_idx;
    logic              do_push;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign top_idx = empty ? '0 : IDX_W'(level - LVL_W'(1));

    // Track the number of live entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (clear) begin
            level <= '0;
        end else if (do_push) begin
            level <= level + LVL_W'(1);
        end else if (pop) begin
            level <= level - LVL_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ADDR_W-1:0] end_q;
        logic [ADDR_W-1:0] ret_q;
        logic [ADDR_W-1:0] start_q;
        logic [UNI_W-1:0]  cnt_q;
        logic [UNI_W-1:0]  inc_q;

        // Load this slot on a push into it, count it down while it is the top.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                end_q   <= '0;
                ret_q   <= '0;
                start_q <= '0;
                cnt_q   <= '0;
                inc_q   <= '0;
            end else if (do_push && !clear && level == LVL_W'(g)) begin
                end_q   <= in_end;
                ret_q   <= in_ret;
                start_q <= in_start;
                cnt_q   <= in_cnt;
                inc_q   <= in_inc;
            end else if (dec_top && !clear && level == LVL_W'(g + 1)) begin
                cnt_q   <= cnt_q - UNI_W'(1);
            end
        end

        assign s_end[g]   = end_q;
        assign s_ret[g]   = ret_q;
        assign s_start[g] = start_q;
        assign s_cnt[g]   = cnt_q;
        assign s_inc[g]   = inc_q;
    end

    assign top_end   = s_end[top_idx];
    assign top_ret   = s_ret[top_idx];
    assign top_start = s_start[top_idx];
    assign top_cnt   = s_cnt[top_idx];
    assign top_inc   = s_inc[top_idx];

endmodule

// File: rtl/shader_flow_seq.sv
// Shader flow-control sequencer top: owns the PC, loop register, overflow
// flag and fetch high-water mark. Each cycle it either closes the top region
// (when the PC reaches its end) or executes the decoded instruction.
// Assumes the decoder fields describe the word at fetch_addr in the same cycle.
module shader_flow_seq
    import shader_flow_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int UNI_W  = 8,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 16,
    parameter int BOOL_N = 16,
    localparam int SEL_W = $clog2(BOOL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] main_offset,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] dest,
    input  logic [CNT_W-1:0]  count,
    input  logic              ref_x,
    input  logic              ref_y,
    input  logic [1:0]        cond_mode,
    input  logic              flag_x,
    input  logic              flag_y,
    input  logic [BOOL_N-1:0] bool_uni,
    input  logic [SEL_W-1:0]  bool_sel,
    input  logic [UNI_W-1:0]  int_x,
    input  logic [UNI_W-1:0]  int_y,
    input  logic [UNI_W-1:0]  int_z,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              issue,
    output logic [UNI_W-1:0]  loop_reg,
    output logic              overflow_err,
    output logic [ADDR_W:0]   high_water
);

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int HW_W  = ADDR_W + 1;

    logic [ADDR_W-1:0] pc_q;
    logic [UNI_W-1:0]  loop_q;
    logic              err_q;
    logic [HW_W-1:0]   hw_q;

    logic              cond_ok;
    logic              bool_ok;
    logic [ADDR_W-1:0] dec_pc;
    logic              push_req;
    logic [ADDR_W-1:0] push_end, push_ret, push_start;
    logic [UNI_W-1:0]  push_cnt, push_inc;
    logic              loop_load;
    logic [UNI_W-1:0]  loop_val;

    logic              stk_empty, stk_full;
    logic [LVL_W-1:0]  stk_level;
    logic [ADDR_W-1:0] top_end, top_ret, top_start;
    logic [UNI_W-1:0]  top_cnt, top_inc;

    logic              top_hit;
    logic              last_pass;
    logic [HW_W-1:0]   fetch_inc;

    assign bool_ok   = bool_uni[bool_sel];
    assign top_hit   = !stk_empty && (pc_q == top_end);
    assign last_pass = (top_cnt == '0);
    assign issue     = !start && !top_hit;
    assign fetch_inc = {1'b0, pc_q} + HW_W'(1);

    flow_cond_eval u_cond (
        .ref_x  (ref_x),
        .ref_y  (ref_y),
        .flag_x (flag_x),
        .flag_y (flag_y),
        .mode   (cond_mode),
        .pass   (cond_ok)
    );

    flow_decode #(
        .ADDR_W (ADDR_W),
        .UNI_W  (UNI_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .pc         (pc_q),
        .op         (op),
        .dest       (dest),
        .count      (count),
        .cond_ok    (cond_ok),
        .bool_ok    (bool_ok),
        .int_x      (int_x),
        .int_y      (int_y),
        .int_z      (int_z),
        .next_pc    (dec_pc),
        .push_req   (push_req),
        .push_end   (push_end),
        .push_ret   (push_ret),
        .push_start (push_start),
        .push_cnt   (push_cnt),
        .push_inc   (push_inc),
        .loop_load  (loop_load),
        .loop_val   (loop_val)
    );

    region_stack #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .UNI_W  (UNI_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .push      (issue && push_req),
        .pop       (!start && top_hit && last_pass),
        .dec_top   (!start && top_hit && !last_pass),
        .in_end    (push_end),
        .in_ret    (push_ret),
        .in_start  (push_start),
        .in_cnt    (push_cnt),
        .in_inc    (push_inc),
        .empty     (stk_empty),
        .full      (stk_full),
        .level     (stk_level),
        .top_end   (top_end),
        .top_ret   (top_ret),
        .top_start (top_start),
        .top_cnt   (top_cnt),
        .top_inc   (top_inc)
    );

    // Advance the PC and the loop, error and high-water state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            loop_q <= '0;
            err_q  <= 1'b0;
            hw_q   <= '0;
        end else if (start) begin
            pc_q   <= main_offset;
            loop_q <= '0;
            err_q  <= 1'b0;
            hw_q   <= '0;
        end else if (top_hit) begin
            loop_q <= loop_q + top_inc;
            pc_q   <= last_pass ? top_ret : top_start;
        end else begin
            pc_q <= dec_pc;
            if (loop_load)           loop_q <= loop_val;
            if (push_req && stk_full) err_q <= 1'b1;
            if (fetch_inc > hw_q)     hw_q  <= fetch_inc;
        end
    end

    assign fetch_addr   = pc_q;
    assign loop_reg     = loop_q;
    assign overflow_err = err_q;
    assign high_water   = hw_q;

endmodule

// File: rtl/shader_flow_seq_checker.sv
// Property checker for the flow-control sequencer, attached by bind.
// Assumes it observes the top ports plus the stack occupancy.
module shader_flow_seq_checker
    import shader_flow_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int UNI_W  = 8,
    parameter int DEPTH  = 16,
    parameter int BOOL_N = 16,
    localparam int SEL_W = $clog2(BOOL_N),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] main_offset,
    input logic [3:0]        op,
    input logic [ADDR_W-1:0] dest,
    input logic              ref_x,
    input logic              ref_y,
    input logic [1:0]        cond_mode,
    input logic              flag_x,
    input logic              flag_y,
    input logic [BOOL_N-1:0] bool_uni,
    input logic [SEL_W-1:0]  bool_sel,
    input logic [UNI_W-1:0]  int_y,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              issue,
    input logic [UNI_W-1:0]  loop_reg,
    input logic              overflow_err,
    input logic [ADDR_W:0]   high_water,
    input logic [LVL_W-1:0]  stk_level
);

    assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fetch_addr == $past(main_offset)) && (high_water == '0)
                  && !overflow_err && (loop_reg == '0));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_SEQ) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_err && !start) |=> overflow_err);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= LVL_W'(DEPTH));

    assert_jump_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_JMPU && bool_uni[bool_sel]) |=> fetch_addr == $past(dest));

    assert_call_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_CALL) |=> fetch_addr == $past(dest));

    assert_if_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_IFU && bool_uni[bool_sel])
            |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    assert_loop_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_LOOP) |=> loop_reg == $past(int_y));

    assert_idle_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !start) |=> high_water == $past(high_water));

    assert_cond_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_JMPC && cond_mode == CM_BOTH && ref_x == flag_x && ref_y == flag_y)
            |=> fetch_addr == $past(dest));

    assert_hw_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> high_water >= $past(high_water));

endmodule

bind shader_flow_seq shader_flow_seq_checker #(
    .ADDR_W (ADDR_W),
    .UNI_W  (UNI_W),
    .DEPTH  (DEPTH),
    .BOOL_N (BOOL_N)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .main_offset  (main_offset),
    .op           (op),
    .dest         (dest),
    .ref_x        (ref_x),
    .ref_y        (ref_y),
    .cond_mode    (cond_mode),
    .flag_x       (flag_x),
    .flag_y       (flag_y),
    .bool_uni     (bool_uni),
    .bool_sel     (bool_sel),
    .int_y        (int_y),
    .fetch_addr   (fetch_addr),
    .issue        (issue),
    .loop_reg     (loop_reg),
    .overflow_err (overflow_err),
    .high_water   (high_water),
    .stk_level    (stk_level)
);

// File: tb/shader_flow_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (queue stack, integer state) run in
// lock-step with the sequencer and compared every clock.
module shader_flow_seq_bench;
    import shader_flow_pkg::*;

    localparam int AW = 8;
    localparam int UW = 8;
    localparam int CW = 8;
    localparam int DP = 4;
    localparam int BN = 8;
    localparam int SW = $clog2(BN);
    localparam int ROM_N = 1 << AW;

    typedef struct packed {
        logic [3:0]    op;
        logic [AW-1:0] dest;
        logic [CW-1:0] cnt;
        logic          rx;
        logic          ry;
        logic [1:0]    cm;
        logic [SW-1:0] bsel;
        logic [UW-1:0] ix;
        logic [UW-1:0] iy;
        logic [UW-1:0] iz;
    } word_t;

    typedef struct packed {
        logic [AW-1:0] e_end;
        logic [AW-1:0] e_ret;
        logic [AW-1:0] e_start;
        logic [UW-1:0] cnt;
        logic [UW-1:0] inc;
    } region_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] main_offset;
    logic [3:0]    op;
    logic [AW-1:0] dest;
    logic [CW-1:0] count;
    logic          ref_x, ref_y;
    logic [1:0]    cond_mode;
    logic          flag_x, flag_y;
    logic [BN-1:0] bool_uni;
    logic [SW-1:0] bool_sel;
    logic [UW-1:0] int_x, int_y, int_z;
    logic [AW-1:0] fetch_addr;
    logic          issue;
    logic [UW-1:0] loop_reg;
    logic          overflow_err;
    logic [AW:0]   high_water;

    always #2 clk = ~clk;

    shader_flow_seq #(
        .ADDR_W (AW), .UNI_W (UW), .CNT_W (CW), .DEPTH (DP), .BOOL_N (BN)
    ) u_shader_flow_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .main_offset (main_offset),
        .op (op), .dest (dest), .count (count), .ref_x (ref_x), .ref_y (ref_y),
        .cond_mode (cond_mode), .flag_x (flag_x), .flag_y (flag_y),
        .bool_uni (bool_uni), .bool_sel (bool_sel),
        .int_x (int_x), .int_y (int_y), .int_z (int_z),
        .fetch_addr (fetch_addr), .issue (issue), .loop_reg (loop_reg),
        .overflow_err (overflow_err), .high_water (high_water)
    );

    word_t         rom [ROM_N];
    logic [AW-1:0] m_pc;
    logic [UW-1:0] m_loop;
    bit            m_err;
    logic [AW:0]   m_hw;
    region_t       m_stk [$];
    string         pc_tag;
    bit            start_req;
    logic [AW-1:0] start_addr;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 0;

    // Compare one observed value with the model's expectation.
    task automatic cmp(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic put(int a, logic [3:0] o, int d, int c, bit rx, bit ry,
                       int cm, int bs, int ix, int iy, int iz);
        rom[a] = '{op: o, dest: AW'(d), cnt: CW'(c), rx: rx, ry: ry, cm: 2'(cm),
                   bsel: SW'(bs), ix: UW'(ix), iy: UW'(iy), iz: UW'(iz)};
    endtask

    task automatic clear_rom();
        for (int a = 0; a < ROM_N; a++) rom[a] = '0;
    endtask

    // Directed program: call, jump, both branch arms, loop, nested unwinding.
    task automatic load_directed();
        clear_rom();
        put(1,  OP_CALL,  10, 2, 0, 0, 0, 0, 0, 0, 0);   // R5
        put(2,  OP_JMPU,  20, 0, 0, 0, 0, 3, 0, 0, 0);   // R4 taken
        put(20, OP_IFC,   23, 2, 1, 0, 1, 0, 0, 0, 0);   // R6 taken, R9 both
        put(25, OP_IFU,   30, 3, 0, 0, 0, 4, 0, 0, 0);   // R6 not taken
        put(33, OP_LOOP,  35, 0, 0, 0, 0, 0, 2, 5, 3);   // R7 three passes
        put(36, OP_JMPC,  90, 0, 0, 0, 2, 0, 0, 0, 0);   // R9 X-only fails
        put(37, OP_JMPC,  50, 0, 1, 1, 0, 0, 0, 0, 0);   // R9 either passes
        put(50, OP_CALLU, 70, 1, 0, 0, 0, 4, 0, 0, 0);   // R5 not taken
        put(51, OP_CALLC, 60, 1, 0, 0, 3, 0, 0, 0, 0);   // R9 Y-only passes
        put(60, OP_LOOP,  60, 0, 0, 0, 0, 0, 0, 1, 1);   // R8 double unwind
        put(56, 4'd12,    0,  0, 0, 0, 0, 0, 0, 0, 0);   // R2 unused code
    endtask

    // Overflow program: a chain of calls deeper than the stack.
    task automatic load_chain();
        clear_rom();
        for (int a = 100; a < 130; a++) put(a, OP_CALL, a + 1, 40, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic load_random();
        for (int a = 0; a < ROM_N; a++)
            put(a, 4'($urandom_range(0, 10)), a + $urandom_range(0, 12), $urandom_range(0, 5),
                1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom_range(0, BN - 1),
                $urandom_range(0, 3), $urandom_range(0, 255), $urandom_range(0, 255));
    endtask

    function automatic bit m_cond(word_t w);
        bit mx = (w.rx == flag_x);
        bit my = (w.ry == flag_y);
        case (w.cm)
            2'd0:    return mx || my;
            2'd1:    return mx && my;
            2'd2:    return mx;
            default: return my;
        endcase
    endfunction

    task automatic m_push(logic [AW-1:0] e, logic [AW-1:0] r, logic [AW-1:0] s,
                          logic [UW-1:0] c, logic [UW-1:0] i);
        if (m_stk.size() >= DP) begin
            m_err = 1;
            pc_tag = "R3";
        end else begin
            m_stk.push_back('{e_end: e, e_ret: r, e_start: s, cnt: c, inc: i});
        end
    endtask

    // Reference behaviour for one clock.
    task automatic model_step(bit st, word_t w);
        region_t t;
        logic [AW:0] nx;
        logic [AW-1:0] tail;
        bit c;
        bit b;
        if (st) begin
            m_pc = start_addr; m_loop = '0; m_err = 0; m_hw = '0;
            m_stk.delete();
            pc_tag = "R1";
        end else if (m_stk.size() != 0 && m_pc == m_stk[$].e_end) begin
            t = m_stk.pop_back();
            m_loop = m_loop + t.inc;
            if (t.cnt == 0) begin
                m_pc = t.e_ret;
            end else begin
                t.cnt = t.cnt - 1;
                m_pc = t.e_start;
                m_stk.push_back(t);
            end
            pc_tag = "R8";
        end else begin
            nx = {1'b0, m_pc} + 1;
            if (nx > m_hw) m_hw = nx;
            c = m_cond(w);
            b = bool_uni[w.bsel];
            tail = w.dest + AW'(w.cnt);
            case (w.op)
                OP_JMPC: begin pc_tag = "R4 R9"; m_pc = c ? w.dest : m_pc + 1; end
                OP_JMPU: begin pc_tag = "R4"; m_pc = b ? w.dest : m_pc + 1; end
                OP_CALL, OP_CALLC, OP_CALLU: begin
                    pc_tag = "R5";
                    if (w.op == OP_CALL || (w.op == OP_CALLC && c) || (w.op == OP_CALLU && b)) begin
                        m_push(tail, m_pc + 1, w.dest, 0, 0);
                        m_pc = w.dest;
                    end else begin
                        m_pc = m_pc + 1;
                    end
                end
                OP_IFC, OP_IFU: begin
                    pc_tag = "R6";
                    if ((w.op == OP_IFC) ? c : b) begin
                        m_push(w.dest, tail, m_pc + 1, 0, 0);
                        m_pc = m_pc + 1;
                    end else begin
                        m_push(tail, tail, w.dest, 0, 0);
                        m_pc = w.dest;
                    end
                end
                OP_LOOP: begin
                    pc_tag = "R7";
                    m_loop = w.iy;
                    m_push(w.dest + 1, w.dest + 1, m_pc + 1, w.ix, w.iz);
                    m_pc = m_pc + 1;
                end
                default: begin pc_tag = "R2"; m_pc = m_pc + 1; end
            endcase
        end
    endtask

    // One cycle: check registered outputs, drive inputs, check issue, step model.
    task automatic tick(bit rnd);
        word_t w;
        bit st;
        bit exp_issue;
        cmp({pc_tag, " fetch_addr"}, fetch_addr, m_pc);
        cmp("R7 R8 loop_reg", loop_reg, m_loop);
        cmp("R3 overflow_err", overflow_err, m_err);
        cmp("R10 high_water", high_water, m_hw);
        st = start_req;
        start_req = 0;
        w = rom[m_pc];
        start = st; main_offset = start_addr;
        op = w.op; dest = w.dest; count = w.cnt; ref_x = w.rx; ref_y = w.ry;
        cond_mode = w.cm; bool_sel = w.bsel; int_x = w.ix; int_y = w.iy; int_z = w.iz;
        if (rnd) begin
            flag_x = 1'($urandom); flag_y = 1'($urandom); bool_uni = BN'($urandom);
        end
        #1;
        exp_issue = !st && !(m_stk.size() != 0 && m_pc == m_stk[$].e_end);
        cmp("R8 R1 issue", issue, exp_issue);
        model_step(st, w);
        @(negedge clk);
    endtask

    task automatic restart(int a);
        start_req = 1;
        start_addr = AW'(a);
    endtask

    initial begin
        rst_n = 0; start = 0; main_offset = '0; op = '0; dest = '0; count = '0;
        ref_x = 0; ref_y = 0; cond_mode = '0; flag_x = 1; flag_y = 0;
        bool_uni = 8'b0000_1000; bool_sel = '0; int_x = '0; int_y = '0; int_z = '0;
        start_req = 0; start_addr = '0; pc_tag = "R1";
        load_directed();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_pc = '0; m_loop = '0; m_err = 0; m_hw = '0; m_stk.delete();
        repeat (80) tick(0);
        load_chain();
        restart(100);
        repeat (20) tick(0);
        load_directed();
        restart(0);
        repeat (12) tick(0);
        for (int r = 0; r < 40; r++) begin
            load_random();
            restart($urandom_range(0, ROM_N - 1));
            repeat (150) tick(1);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule